// File: doc/BRIEF.md
# 40-bit Accumulator Status Flag Generator

This block holds the seven status flags of a 40-bit accumulator datapath and rewrites them after an arithmetic or multiply step. The datapath presents the destination operand, the source operand and the 40-bit result, together with one rule selector per flag, and raises an update strobe for one cycle. On that clock edge each flag whose selector is non-zero takes the value its rule gives. Each flag whose selector is zero keeps its old value.

The carry and overflow flags each offer several formulas, taken from the sign bits of the operands and the result. Two carry formulas pick between the add form and the subtract form from operand bit 31 or bit 15, so that mixed-width operations get the right carry. The sticky overflow flag collects every overflow until it is cleared by a synchronous clear input. The zero, negative, extension and unnormalized flags look at fields of the result only. All flags are registers, so they show the new values one cycle after the strobe.

Top module: `psw_flag_gen`

## Requirements
- R1: A synchronous active-high reset clears all seven flags (C, V, SV, Z, N, E, U) to 0.
- R2: When `upd` is low, C, V, Z, N, E and U keep their values whatever the selectors and operands are. After an update, the new flag values appear at the outputs on the clock edge where `upd` is sampled high.
- R3: A selector code of 0 leaves its flag unchanged during an update. Carry and overflow codes 8 to 15 also leave their flag unchanged, and so does negative code 3.
- R4: Carry code 1 forces C to 0. Code 2 (add) gives (d39&s39)|(~r39&(d39|s39)). Code 3 (subtract) gives (d39&~s39)|(~r39&(d39|~s39)).
- R5: Carry code 5 gives ~d39&~r39. Carry code 7 gives d39&~r39.
- R6: Carry code 4 uses s15 in place of s39, and takes the add form when d39 XOR s15 is 1 and the subtract form otherwise. Carry code 6 uses s39, and takes the add form when d39 XOR s31 is 0 and the subtract form otherwise.
- R7: Overflow code 1 forces V to 0. Code 2 gives (d39&s39&~r39)|(~d39&~s39&r39). Code 3 gives (d39&~s39&~r39)|(~d39&s39&r39). Code 4 gives d39&r39, code 5 gives ~d39&r39, code 6 gives r39 and code 7 gives d39&~r39.
- R8: If V is 1 after an update, SV is set to 1 on the same edge. SV then stays 1 until it is cleared.
- R9: `sv_clr` clears SV on the next edge. If an update on the same edge leaves V at 1, the set wins and SV stays 1.
- R10: Zero code 1 and code 3 set Z when all 40 result bits are 0. Code 2 sets Z when result bits 31..16 are 0.
- R11: Negative code 1 copies result bit 39 into N. Code 2 copies result bit 31.
- R12: With the extension selector at 1, E is 0 when result bits 39..31 are all 0 or all 1, and 1 otherwise.
- R13: With the unnormalized selector at 1, U becomes NOT(r31 XOR r30).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe, one cycle per operation |
| sv_clr | input | 1 | Synchronous clear of the sticky overflow flag |
| op_d | input | 40 | Destination operand |
| op_s | input | 40 | Source operand |
| res | input | 40 | Operation result |
| c_rule | input | 4 | Carry rule selector |
| v_rule | input | 4 | Overflow rule selector |
| z_rule | input | 2 | Zero rule selector |
| n_rule | input | 2 | Negative rule selector |
| e_rule | input | 1 | Extension update enable |
| u_rule | input | 1 | Unnormalized update enable |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_sv | output | 1 | Sticky overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_e | output | 1 | Extension |
| flag_u | output | 1 | Unnormalized |

## Verification
The assertions assume that the operands and selectors are stable at the clock edge where `upd` is high, and that nothing else writes the flags. The checks that look back one cycle through `$past` rely on this. The bench drives all inputs on the falling edge and holds each operation for exactly one rising edge. After reset it only drives defined values, so no check ever sees unknown inputs.

// File: rtl/psw_flag_pkg.sv
package psw_flag_pkg;
  localparam logic [3:0] CR_KEEP  = 4'd0;
  localparam logic [3:0] CR_ZERO  = 4'd1;
  localparam logic [3:0] CR_ADD   = 4'd2;
  localparam logic [3:0] CR_SUB   = 4'd3;
  localparam logic [3:0] CR_MIX15 = 4'd4;
  localparam logic [3:0] CR_NDNR  = 4'd5;
  localparam logic [3:0] CR_MIX31 = 4'd6;
  localparam logic [3:0] CR_DNR   = 4'd7;

  localparam logic [3:0] VR_KEEP  = 4'd0;
  localparam logic [3:0] VR_ZERO  = 4'd1;
  localparam logic [3:0] VR_ADD   = 4'd2;
  localparam logic [3:0] VR_SUB   = 4'd3;
  localparam logic [3:0] VR_DR    = 4'd4;
  localparam logic [3:0] VR_NDR   = 4'd5;
  localparam logic [3:0] VR_R     = 4'd6;
  localparam logic [3:0] VR_DNR   = 4'd7;

  localparam logic [1:0] ZR_KEEP  = 2'd0;
  localparam logic [1:0] ZR_FULL  = 2'd1;
  localparam logic [1:0] ZR_MID   = 2'd2;
  localparam logic [1:0] ZR_FULL2 = 2'd3;

  localparam logic [1:0] NR_KEEP  = 2'd0;
  localparam logic [1:0] NR_TOP   = 2'd1;
  localparam logic [1:0] NR_WORD  = 2'd2;

  typedef struct packed {
    logic c;
    logic v;
    logic sv;
    logic z;
    logic n;
    logic e;
    logic u;
  } psw_flags_t;

  function automatic logic carry_add(input logic a, input logic b, input logic r);
    return (a & b) | (~r & (a | b));
  endfunction

  function automatic logic carry_sub(input logic a, input logic b, input logic r);
    return (a & ~b) | (~r & (a | ~b));
  endfunction
endpackage

// File: rtl/psw_carry_rule.sv
module psw_carry_rule
  import psw_flag_pkg::*;
(
  input  logic       d_top,
  input  logic       s_top,
  input  logic       s_word,
  input  logic       s_half,
  input  logic       r_top,
  input  logic [3:0] sel,
  output logic       wr_en,
  output logic       val
);
  always_comb begin
    wr_en = 1'b1;
    val   = 1'b0;
    unique case (sel)
      CR_ZERO:  val = 1'b0;
      CR_ADD:   val = carry_add(d_top, s_top, r_top);
      CR_SUB:   val = carry_sub(d_top, s_top, r_top);
      CR_MIX15: val = (d_top ^ s_half) ? carry_add(d_top, s_half, r_top)
                                       : carry_sub(d_top, s_half, r_top);
      CR_NDNR:  val = ~d_top & ~r_top;
      CR_MIX31: val = (d_top ^ s_word) ? carry_sub(d_top, s_top, r_top)
                                       : carry_add(d_top, s_top, r_top);
      CR_DNR:   val = d_top & ~r_top;
      default:  wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/psw_ovf_rule.sv
module psw_ovf_rule
  import psw_flag_pkg::*;
(
  input  logic       d_top,
  input  logic       s_top,
  input  logic       r_top,
  input  logic [3:0] sel,
  output logic       wr_en,
  output logic       val
);
  always_comb begin
    wr_en = 1'b1;
    val   = 1'b0;
    unique case (sel)
      VR_ZERO: val = 1'b0;
      VR_ADD:  val = (d_top & s_top & ~r_top) | (~d_top & ~s_top & r_top);
      VR_SUB:  val = (d_top & ~s_top & ~r_top) | (~d_top & s_top & r_top);
      VR_DR:   val = d_top & r_top;
      VR_NDR:  val = ~d_top & r_top;
      VR_R:    val = r_top;
      VR_DNR:  val = d_top & ~r_top;
      default: wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/psw_field_rule.sv
module psw_field_rule
  import psw_flag_pkg::*;
#(
  parameter int DATA_W   = 40,
  parameter int WORD_MSB = 31,
  parameter int HALF_MSB = 15
) (
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        z_sel,
  input  logic [1:0]        n_sel,
  input  logic              e_sel,
  input  logic              u_sel,
  output logic              z_en,
  output logic              z_val,
  output logic              n_en,
  output logic              n_val,
  output logic              e_en,
  output logic              e_val,
  output logic              u_en,
  output logic              u_val
);
  localparam int EXT_W = DATA_W - WORD_MSB;

  logic [EXT_W-1:0] ext_field;
  assign ext_field = res[DATA_W-1:WORD_MSB];

  always_comb begin
    z_en  = 1'b1;
    z_val = 1'b0;
    unique case (z_sel)
      ZR_MID:              z_val = ~|res[WORD_MSB:HALF_MSB+1];
      ZR_FULL, ZR_FULL2:   z_val = ~|res;
      default:             z_en  = 1'b0;
    endcase
  end

  always_comb begin
    n_en  = 1'b1;
    n_val = 1'b0;
    unique case (n_sel)
      NR_TOP:  n_val = res[DATA_W-1];
      NR_WORD: n_val = res[WORD_MSB];
      default: n_en  = 1'b0;
    endcase
  end

  assign e_en  = e_sel;
  assign e_val = ~((&ext_field) | (~|ext_field));
  assign u_en  = u_sel;
  assign u_val = ~(res[WORD_MSB] ^ res[WORD_MSB-1]);
endmodule

// File: rtl/psw_flag_gen.sv
module psw_flag_gen
  import psw_flag_pkg::*;
#(
  parameter int DATA_W   = 40,
  parameter int WORD_MSB = 31,
  parameter int HALF_MSB = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              sv_clr,
  input  logic [DATA_W-1:0] op_d,
  input  logic [DATA_W-1:0] op_s,
  input  logic [DATA_W-1:0] res,
  input  logic [3:0]        c_rule,
  input  logic [3:0]        v_rule,
  input  logic [1:0]        z_rule,
  input  logic [1:0]        n_rule,
  input  logic              e_rule,
  input  logic              u_rule,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_sv,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_e,
  output logic              flag_u
);
  localparam int TOP = DATA_W - 1;

  psw_flags_t q, nxt;
  logic c_en, c_val, v_en, v_val;
  logic z_en, z_val, n_en, n_val, e_en, e_val, u_en, u_val;
  logic v_after;

  psw_carry_rule u_carry (
    .d_top (op_d[TOP]),
    .s_top (op_s[TOP]),
    .s_word(op_s[WORD_MSB]),
    .s_half(op_s[HALF_MSB]),
    .r_top (res[TOP]),
    .sel   (c_rule),
    .wr_en (c_en),
    .val   (c_val)
  );

  psw_ovf_rule u_ovf (
    .d_top(op_d[TOP]),
    .s_top(op_s[TOP]),
    .r_top(res[TOP]),
    .sel  (v_rule),
    .wr_en(v_en),
    .val  (v_val)
  );

  psw_field_rule #(
    .DATA_W  (DATA_W),
    .WORD_MSB(WORD_MSB),
    .HALF_MSB(HALF_MSB)
  ) u_field (
    .res  (res),
    .z_sel(z_rule),
    .n_sel(n_rule),
    .e_sel(e_rule),
    .u_sel(u_rule),
    .z_en (z_en),
    .z_val(z_val),
    .n_en (n_en),
    .n_val(n_val),
    .e_en (e_en),
    .e_val(e_val),
    .u_en (u_en),
    .u_val(u_val)
  );

  assign v_after = v_en ? v_val : q.v;

  always_comb begin
    nxt = q;
    if (upd) begin
      if (c_en) nxt.c = c_val;
      if (v_en) nxt.v = v_val;
      if (z_en) nxt.z = z_val;
      if (n_en) nxt.n = n_val;
      if (e_en) nxt.e = e_val;
      if (u_en) nxt.u = u_val;
    end
    if (upd && v_after) nxt.sv = 1'b1;
    else if (sv_clr)    nxt.sv = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign flag_c  = q.c;
  assign flag_v  = q.v;
  assign flag_sv = q.sv;
  assign flag_z  = q.z;
  assign flag_n  = q.n;
  assign flag_e  = q.e;
  assign flag_u  = q.u;
endmodule

// File: rtl/psw_flag_gen_chk.sv
module psw_flag_gen_chk #(
  parameter int DATA_W   = 40,
  parameter int WORD_MSB = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              upd,
  input logic              sv_clr,
  input logic [DATA_W-1:0] res,
  input logic [3:0]        c_rule,
  input logic [1:0]        n_rule,
  input logic              e_rule,
  input logic              u_rule,
  input logic              flag_c,
  input logic              flag_v,
  input logic              flag_sv,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_e,
  input logic              flag_u
);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(flag_c) && $stable(flag_v) && $stable(flag_z) &&
              $stable(flag_n) && $stable(flag_e) && $stable(flag_u)));

  assert_keep_code_R3: assert property (@(posedge clk) disable iff (rst)
    (upd && c_rule == 4'd0) |=> $stable(flag_c));

  assert_sv_follows_v_R8: assert property (@(posedge clk) disable iff (rst)
    upd |=> (!flag_v || flag_sv));

  assert_sv_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_sv && !sv_clr) |=> flag_sv);

  assert_sv_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (sv_clr && !upd) |=> !flag_sv);

  assert_neg_top_R11: assert property (@(posedge clk) disable iff (rst)
    (upd && n_rule == 2'd1) |=> (flag_n == $past(res[DATA_W-1])));

  assert_ext_R12: assert property (@(posedge clk) disable iff (rst)
    (upd && e_rule) |=> (flag_e == !((&$past(res[DATA_W-1:WORD_MSB])) ||
                                     !(|$past(res[DATA_W-1:WORD_MSB])))));

  assert_unnorm_R13: assert property (@(posedge clk) disable iff (rst)
    (upd && u_rule) |=> (flag_u == ($past(res[WORD_MSB]) == $past(res[WORD_MSB-1]))));
endmodule

bind psw_flag_gen psw_flag_gen_chk #(
  .DATA_W  (DATA_W),
  .WORD_MSB(WORD_MSB)
) i_psw_flag_gen_chk (
  .clk    (clk),
  .rst    (rst),
  .upd    (upd),
  .sv_clr (sv_clr),
  .res    (res),
  .c_rule (c_rule),
  .n_rule (n_rule),
  .e_rule (e_rule),
  .u_rule (u_rule),
  .flag_c (flag_c),
  .flag_v (flag_v),
  .flag_sv(flag_sv),
  .flag_z (flag_z),
  .flag_n (flag_n),
  .flag_e (flag_e),
  .flag_u (flag_u)
);

// File: tb/test_psw_flag_gen.sv
module test_psw_flag_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic        sv_clr = 1'b0;
  logic [39:0] op_d = '0;
  logic [39:0] op_s = '0;
  logic [39:0] res = '0;
  logic [3:0]  c_rule = '0;
  logic [3:0]  v_rule = '0;
  logic [1:0]  z_rule = '0;
  logic [1:0]  n_rule = '0;
  logic        e_rule = 1'b0;
  logic        u_rule = 1'b0;
  logic flag_c, flag_v, flag_sv, flag_z, flag_n, flag_e, flag_u;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psw_flag_gen i_psw_flag_gen (
    .clk(clk), .rst(rst), .upd(upd), .sv_clr(sv_clr),
    .op_d(op_d), .op_s(op_s), .res(res),
    .c_rule(c_rule), .v_rule(v_rule), .z_rule(z_rule), .n_rule(n_rule),
    .e_rule(e_rule), .u_rule(u_rule),
    .flag_c(flag_c), .flag_v(flag_v), .flag_sv(flag_sv), .flag_z(flag_z),
    .flag_n(flag_n), .flag_e(flag_e), .flag_u(flag_u)
  );

  // flag vector order: {C, V, SV, Z, N, E, U}
  function automatic logic [6:0] flags();
    return {flag_c, flag_v, flag_sv, flag_z, flag_n, flag_e, flag_u};
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: flags CVSZNEU actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  // one update: drive on falling edge, hold across one rising edge
  task automatic op(input logic [39:0] d, input logic [39:0] s, input logic [39:0] r,
                    input logic [3:0] cr, input logic [3:0] vr, input logic [1:0] zr,
                    input logic [1:0] nr, input logic er, input logic ur, input logic clr);
    op_d = d; op_s = s; res = r;
    c_rule = cr; v_rule = vr; z_rule = zr; n_rule = nr; e_rule = er; u_rule = ur;
    upd = 1'b1; sv_clr = clr;
    @(negedge clk);
    upd = 1'b0; sv_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", flags(), 7'b0000000);
  endtask

  task automatic t_add_all();
    // C add=1, V add=1, SV=1, Z full=1, N top=0, E=0, U=1
    op(40'h80_0000_0000, 40'h80_0000_0000, 40'h0, 4'd2, 4'd2, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    check("R4 R7 R8 R10 R11 R12 R13 add", flags(), 7'b1111001);
  endtask

  task automatic t_sub_all();
    // C sub=0, V sub=1, SV=1, Z=0, N=1, E=1, U=1
    op(40'h0, 40'h80_0000_0000, 40'h80_0000_0000, 4'd3, 4'd3, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    check("R4 R7 R12 sub", flags(), 7'b0110111);
  endtask

  task automatic t_hold();
    // no strobe with live selectors: nothing changes
    op_d = 40'hFF_FFFF_FFFF; res = 40'h0; c_rule = 4'd1; v_rule = 4'd1; z_rule = 2'd2;
    n_rule = 2'd2; e_rule = 1'b1; u_rule = 1'b1;
    @(negedge clk);
    check("R2 idle hold", flags(), 7'b0110111);
    // strobe with all keep codes, plus unused codes 9/12 and negative code 3
    op(40'h0, 40'h0, 40'h0, 4'd0, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R3 keep codes", flags(), 7'b0110111);
    op(40'h0, 40'h0, 40'h0, 4'd9, 4'd12, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0);
    check("R3 unused codes", flags(), 7'b0110111);
  endtask

  task automatic t_sticky();
    op(40'h0, 40'h0, 40'h1, 4'd1, 4'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R8 SV sticky after V=0", flag_sv, 1'b1);
    check_bit("R4 carry forced zero", flag_c, 1'b0);
    sv_clr = 1'b1;
    @(negedge clk);
    sv_clr = 1'b0;
    check_bit("R9 SV cleared", flag_sv, 1'b0);
    // clear with simultaneous overflow: set wins (V code 6, r39=1)
    op(40'h0, 40'h0, 40'h80_0000_0000, 4'd0, 4'd6, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    check_bit("R9 set wins over clear", flag_sv, 1'b1);
    check_bit("R7 V code 6", flag_v, 1'b1);
  endtask

  task automatic t_carry_mix();
    op(40'h0, 40'h8000, 40'h0, 4'd4, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R6 code4 add form", flag_c, 1'b1);
    op(40'h80_0000_0000, 40'h8000, 40'h80_0000_0000, 4'd4, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R6 code4 sub form", flag_c, 1'b0);
    op(40'h0, 40'h80_0000_0000, 40'h0, 4'd6, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R6 code6 add form", flag_c, 1'b1);
    op(40'h0, 40'h80_8000_0000, 40'h0, 4'd6, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R6 code6 sub form", flag_c, 1'b0);
  endtask

  task automatic t_carry_single();
    op(40'h0, 40'h0, 40'h0, 4'd5, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R5 code5 set", flag_c, 1'b1);
    op(40'h0, 40'h0, 40'h80_0000_0000, 4'd5, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R5 code5 clear", flag_c, 1'b0);
    op(40'h80_0000_0000, 40'h0, 40'h0, 4'd7, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R5 code7 set", flag_c, 1'b1);
  endtask

  task automatic t_ovf_rules();
    op(40'h80_0000_0000, 40'h0, 40'h80_0000_0000, 4'd0, 4'd4, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R7 code4", flag_v, 1'b1);
    op(40'h80_0000_0000, 40'h0, 40'h80_0000_0000, 4'd0, 4'd5, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R7 code5 clear", flag_v, 1'b0);
    op(40'h0, 40'h0, 40'h80_0000_0000, 4'd0, 4'd5, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R7 code5 set", flag_v, 1'b1);
    op(40'h80_0000_0000, 40'h0, 40'h0, 4'd0, 4'd7, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R7 code7", flag_v, 1'b1);
    op(40'h0, 40'h0, 40'h0, 4'd0, 4'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R7 code1 zero", flag_v, 1'b0);
  endtask

  task automatic t_fields();
    op(40'h0, 40'h0, 40'h12_0000_FFFF, 4'd0, 4'd0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R10 mid field zero", flag_z, 1'b1);
    op(40'h0, 40'h0, 40'h12_0000_FFFF, 4'd0, 4'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R10 full nonzero", flag_z, 1'b0);
    op(40'h0, 40'h0, 40'h0, 4'd0, 4'd0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
    check_bit("R10 code3 zero", flag_z, 1'b1);
    op(40'h0, 40'h0, 40'h00_8000_0000, 4'd0, 4'd0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0);
    check_bit("R11 word sign", flag_n, 1'b1);
    check_bit("R12 ext set", flag_e, 1'b1);
    check_bit("R13 unnorm r31!=r30", flag_u, 1'b0);
    op(40'h0, 40'h0, 40'h00_8000_0000, 4'd0, 4'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    check_bit("R11 top sign", flag_n, 1'b0);
    op(40'h0, 40'h0, 40'hFF_C000_0000, 4'd0, 4'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
    check_bit("R12 ext all ones", flag_e, 1'b0);
    check_bit("R13 unnorm r31==r30", flag_u, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_add_all();
    t_sub_all();
    t_hold();
    t_sticky();
    t_carry_mix();
    t_carry_single();
    t_ovf_rules();
    t_fields();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after use", flags(), 7'b0000000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule